// File: doc/BRIEF.md
# Dual-Address DMA Channel

A single DMA channel that copies a block of bytes from a source region to a destination region. Every transfer unit is a source read phase followed by a destination write phase on a 32-bit memory master port with byte enables. The width of each side is programmed on its own (byte, 16-bit word, 32-bit long or a 16-byte line of four 32-bit beats). The channel gathers narrow reads into a wider write, or spreads one wide read over several narrow writes, and places every byte on the lane that matches its address.

Software loads a source address, a destination address and a byte count through a small word-indexed register port, then writes the mode word with its run bit set. The channel either runs the whole block back to back or, in cycle-steal mode, moves one unit for each pulse on the external request input. Completion is reported by a sticky done flag and an optional interrupt. Bad programming is refused with a configuration error flag.

Top module: `dma_dual_chan`

## Requirements
- R1: After reset every readable register reads zero, `mem_req_o` and `irq_o` are low. The register index map is 0 source address, 1 destination address, 2 byte count, 3 mode, 4 status.
- R2: A unit reads the source and then writes the destination. A byte at address `a` travels on bits `[8*a[1:0]+7 : 8*a[1:0]]` with `mem_be_o[a[1:0]]` set. A request is held with stable address and direction until `mem_ack_i`.
- R3: The size codes are 00 = 32-bit, 01 = byte, 10 = 16-bit, 11 = line (16 bytes as four 32-bit beats). The mode word holds the source size in bits [1:0] and the destination size in bits [3:2].
- R4: Mode bit 4 (source) and bit 5 (destination) select static addressing when 1. When 0, the address advances by the beat width after each beat.
- R5: The unit size is the larger of the two sizes. The 24-bit byte count drops by the unit size after each unit's last write, and it reads zero after a normal completion.
- R6: Packing and unpacking keep byte order: the k-th byte read becomes the k-th byte written.
- R7: With mode bit 6 set, the channel performs exactly one unit per pulse on `ext_req_i` and is idle on the bus between pulses.
- R8: Starting with a count that is not a multiple of the unit size, or with an incrementing address not aligned to its size, sets status bit 2 and issues no bus cycle.
- R9: Status bit 1 (done) is sticky. Writing status with bit 1 set clears done and the error flag. `irq_o` equals done AND mode bit 7.
- R10: Writing the mode word with bit 8 (run) clear while busy stops the channel after the beat in flight. Done stays low and status bit 0 (busy) falls.
- R11: Writes to the address and count registers while busy are ignored.
- R12: A valid start with a count of zero sets done at once with no bus cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| ext_req_i | input | 1 | External unit request pulse (cycle-steal) |
| irq_o | output | 1 | Completion interrupt |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_be_o | output | 4 | Byte lane enables for writes |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ack |
| mem_ack_i | input | 1 | Access completion |

## Verification
The bench builds the block with its defaults: a 32-bit address and a 24-bit count. It attaches a 256-byte memory model that acknowledges every beat after one wait cycle, so the request-hold rule is exercised on every access. With every source byte distinct, each combination of byte, word, long and line sizes with static or incrementing sides can be compared against a byte-level copy model. The 24-bit count leaves room for counts that stress the multiple-of-unit checks without long runs.

// File: rtl/dma_dual_pkg.sv
package dma_dual_pkg;
  localparam int BUS_BYTES  = 4;
  localparam int LINE_BYTES = 16;
  localparam int MODE_W     = 9;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_CNT  = 3'd2;
  localparam logic [2:0] REG_MODE = 3'd3;
  localparam logic [2:0] REG_STAT = 3'd4;

  typedef struct packed {
    logic       run;
    logic       irq_en;
    logic       steal;
    logic       dst_fix;
    logic       src_fix;
    logic [1:0] dst_sz;
    logic [1:0] src_sz;
  } dma_mode_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RD, ST_WR} dma_state_e;

  function automatic logic [4:0] size_bytes(input logic [1:0] code);
    case (code)
      2'b01:   return 5'd1;
      2'b10:   return 5'd2;
      2'b11:   return 5'd16;
      default: return 5'd4;
    endcase
  endfunction

  function automatic logic [2:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'b01:   return 3'd1;
      2'b10:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [4:0] unit_bytes(input dma_mode_t m);
    logic [4:0] s, d;
    s = size_bytes(m.src_sz);
    d = size_bytes(m.dst_sz);
    return (s > d) ? s : d;
  endfunction
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_dual_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              eng_busy_i,
  input  logic              eng_done_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output dma_mode_t         mode_o,
  output logic              start_o,
  output logic              abort_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              irq_o,
  output logic              wr_src_o,
  output logic              wr_dst_o,
  output logic              wr_cnt_o
);
  dma_mode_t  mode_q, new_mode;
  logic       done_q, err_q, start_q;
  logic       mode_wr, bad_cfg;
  logic [4:0] ub, sb, db;

  assign new_mode = dma_mode_t'(wdata_i[MODE_W-1:0]);
  assign mode_wr  = we_i && (addr_i == REG_MODE);
  assign busy_o   = eng_busy_i | start_q;

  always_comb begin
    ub = unit_bytes(new_mode);
    sb = size_bytes(new_mode.src_sz);
    db = size_bytes(new_mode.dst_sz);
    bad_cfg = ((cnt_i[4:0] & (ub - 5'd1)) != 5'd0)
           || (!new_mode.src_fix && ((src_i[4:0] & (sb - 5'd1)) != 5'd0))
           || (!new_mode.dst_fix && ((dst_i[4:0] & (db - 5'd1)) != 5'd0));
  end

  assign wr_src_o = we_i && (addr_i == REG_SRC) && !busy_o;
  assign wr_dst_o = we_i && (addr_i == REG_DST) && !busy_o;
  assign wr_cnt_o = we_i && (addr_i == REG_CNT) && !busy_o;
  assign abort_o  = mode_wr && busy_o && !new_mode.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (eng_done_i) begin
        done_q     <= 1'b1;
        mode_q.run <= 1'b0;
      end
      if (mode_wr) begin
        if (!busy_o) begin
          mode_q <= new_mode;
          if (new_mode.run) begin
            if (bad_cfg) begin
              err_q      <= 1'b1;
              mode_q.run <= 1'b0;
            end else if (cnt_i == '0) begin
              done_q     <= 1'b1;
              mode_q.run <= 1'b0;
            end else begin
              start_q <= 1'b1;
            end
          end
        end else if (!new_mode.run) begin
          mode_q.run <= 1'b0;
        end
      end
      if (we_i && (addr_i == REG_STAT) && wdata_i[1]) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end
    end
  end

  assign mode_o  = mode_q;
  assign start_o = start_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign irq_o   = done_q & mode_q.irq_en;

  AST_ERR_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> !eng_busy_i && !start_q); // R8
  AST_CLEAR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_STAT && wdata_i[1] && !eng_done_i) |=> !done_q && !irq_o); // R9
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_dual_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dma_mode_t         mode_i,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic              ext_req_i,
  input  logic              wr_src_i,
  input  logic              wr_dst_i,
  input  logic              wr_cnt_i,
  input  logic [31:0]       wdata_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i
);
  dma_state_e        state_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [4:0]        off_q, ub;
  logic [2:0]        sbw, dbw;
  logic              pend_q, abort_q, stop_now, done_q;
  logic [7:0]        buf_q [LINE_BYTES];
  logic [7:0]        rd_lane [BUS_BYTES];

  assign ub       = unit_bytes(mode_i);
  assign sbw      = beat_bytes(mode_i.src_sz);
  assign dbw      = beat_bytes(mode_i.dst_sz);
  assign stop_now = abort_i | abort_q;

  // byte k of a beat sits on the lane given by the address low bits
  always_comb begin
    for (int k = 0; k < BUS_BYTES; k++)
      rd_lane[k] = mem_rdata_i[8*int'(2'(src_q[1:0] + 2'(k))) +: 8];
  end

  always_comb begin
    mem_wdata_o = '0;
    mem_be_o    = '0;
    if (state_q == ST_WR) begin
      for (int k = 0; k < BUS_BYTES; k++) begin
        if (k < int'(dbw)) begin
          mem_wdata_o[8*int'(2'(dst_q[1:0] + 2'(k))) +: 8] = buf_q[4'(off_q) + 4'(k)];
          mem_be_o[2'(dst_q[1:0] + 2'(k))] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
      pend_q  <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      for (int i = 0; i < LINE_BYTES; i++) buf_q[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        if (wr_src_i) src_q <= wdata_i[ADDR_W-1:0];
        if (wr_dst_i) dst_q <= wdata_i[ADDR_W-1:0];
        if (wr_cnt_i) cnt_q <= wdata_i[CNT_W-1:0];
        if (start_i) begin
          state_q <= mode_i.steal ? ST_WAIT : ST_RD;
          off_q   <= '0;
          pend_q  <= 1'b0;
          abort_q <= 1'b0;
        end
      end else begin
        if (ext_req_i && mode_i.steal) pend_q <= 1'b1;
        if (abort_i) abort_q <= 1'b1;
      end
      case (state_q)
        ST_WAIT: begin
          if (stop_now) begin
            state_q <= ST_IDLE;
          end else if (pend_q) begin
            pend_q  <= 1'b0;
            state_q <= ST_RD;
          end
        end
        ST_RD: if (mem_ack_i) begin
          for (int k = 0; k < BUS_BYTES; k++)
            if (k < int'(sbw)) buf_q[4'(off_q) + 4'(k)] <= rd_lane[k];
          if (!mode_i.src_fix) src_q <= src_q + ADDR_W'(sbw);
          if (off_q + 5'(sbw) == ub) begin
            off_q   <= '0;
            state_q <= ST_WR;
          end else begin
            off_q <= off_q + 5'(sbw);
          end
          if (stop_now) state_q <= ST_IDLE;
        end
        ST_WR: if (mem_ack_i) begin
          if (!mode_i.dst_fix) dst_q <= dst_q + ADDR_W'(dbw);
          if (off_q + 5'(dbw) == ub) begin
            off_q <= '0;
            cnt_q <= cnt_q - CNT_W'(ub);
            if (cnt_q == CNT_W'(ub)) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= mode_i.steal ? ST_WAIT : ST_RD;
            end
          end else begin
            off_q <= off_q + 5'(dbw);
          end
          if (stop_now) state_q <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign mem_req_o  = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o   = (state_q == ST_WR);
  assign mem_addr_o = (state_q == ST_WR) ? dst_q : src_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign cnt_o      = cnt_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)); // R2
  AST_BE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (mem_be_o != 4'b0)); // R2
  AST_CNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (cnt_q <= $past(cnt_q))); // R5
  AST_DONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cnt_q == '0) && !busy_o); // R5
  AST_STEAL_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && $past(state_q) == ST_WAIT) |-> $past(pend_q)); // R7
endmodule

// File: rtl/dma_dual_chan.sv
module dma_dual_chan
  import dma_dual_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              ext_req_i,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [3:0]        mem_be_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i
);
  dma_mode_t         mode;
  logic              start, abort, busy, done, err, eng_busy, eng_done;
  logic              wr_src, wr_dst, wr_cnt;
  logic [ADDR_W-1:0] src, dst;
  logic [CNT_W-1:0]  cnt;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .eng_busy_i(eng_busy), .eng_done_i(eng_done),
    .src_i(src), .dst_i(dst), .cnt_i(cnt),
    .mode_o(mode), .start_o(start), .abort_o(abort),
    .busy_o(busy), .done_o(done), .err_o(err), .irq_o(irq_o),
    .wr_src_o(wr_src), .wr_dst_o(wr_dst), .wr_cnt_o(wr_cnt)
  );

  dma_xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_engine (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .mode_i(mode), .start_i(start), .abort_i(abort), .ext_req_i(ext_req_i),
    .wr_src_i(wr_src), .wr_dst_i(wr_dst), .wr_cnt_i(wr_cnt), .wdata_i(reg_wdata_i),
    .src_o(src), .dst_o(dst), .cnt_o(cnt),
    .busy_o(eng_busy), .done_o(eng_done),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  always_comb begin
    case (reg_addr_i)
      REG_SRC:  reg_rdata_o = 32'(src);
      REG_DST:  reg_rdata_o = 32'(dst);
      REG_CNT:  reg_rdata_o = 32'(cnt);
      REG_MODE: reg_rdata_o = 32'(mode);
      REG_STAT: reg_rdata_o = {29'b0, err, done, busy};
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/test_dma_dual_chan.sv
module test_dma_dual_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ext_req = 1'b0;
  logic        irq, mreq, mwe, ack = 1'b0, init_mem = 1'b0;
  logic [31:0] maddr, mwdata, mrdata;
  logic [3:0]  mbe;
  logic [31:0] mem [64];
  int          checks = 0, failures = 0, rd_beats = 0, wr_beats = 0;

  always #10 clk = ~clk;

  dma_dual_chan i_dma_dual_chan (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ext_req_i(ext_req), .irq_o(irq),
    .mem_req_o(mreq), .mem_we_o(mwe), .mem_addr_o(maddr), .mem_be_o(mbe),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_ack_i(ack)
  );

  function automatic logic [7:0] init_byte(input int b);
    return 8'((b * 37 + 11) & 255);
  endfunction

  assign mrdata = mem[maddr[7:2]];

  always @(posedge clk) begin
    ack <= mreq && !ack;
    if (mreq && ack) begin
      if (mwe) wr_beats <= wr_beats + 1; else rd_beats <= rd_beats + 1;
      if (mwe)
        for (int l = 0; l < 4; l++)
          if (mbe[l]) mem[maddr[7:2]][8*l +: 8] <= mwdata[8*l +: 8];
    end
    if (init_mem)
      for (int j = 0; j < 64; j++)
        mem[j] <= {init_byte(4*j+3), init_byte(4*j+2), init_byte(4*j+1), init_byte(4*j)};
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic reload_mem();
    @(negedge clk); init_mem = 1'b1;
    @(negedge clk); init_mem = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] st;
    for (int n = 0; n < 3000; n++) begin
      rd_reg(3'd4, st);
      if (st[1]) break;
    end
  endtask

  // mode: [1:0] src size, [3:2] dst size, 4 src static, 5 dst static, 6 steal, 7 irq, 8 run
  function automatic logic [31:0] mk_mode(input logic [1:0] ss, input logic [1:0] ds,
                                          input bit sf, input bit df, input bit st, input bit ie);
    return {23'b0, 1'b1, ie, st, df, sf, ds, ss};
  endfunction

  // {src_sz, dst_sz, src_fix, dst_fix, 2'b0, count, src, dst}
  localparam logic [31:0] VEC [6] = '{
    {2'b00, 2'b00, 1'b0, 1'b0, 2'b0, 8'd16, 8'h00, 8'h80},
    {2'b01, 2'b00, 1'b0, 1'b0, 2'b0, 8'd8,  8'h03, 8'h84},
    {2'b00, 2'b01, 1'b0, 1'b1, 2'b0, 8'd8,  8'h10, 8'hC1},
    {2'b10, 2'b10, 1'b0, 1'b0, 2'b0, 8'd6,  8'h22, 8'h92},
    {2'b11, 2'b11, 1'b0, 1'b0, 2'b0, 8'd32, 8'h20, 8'hA0},
    {2'b01, 2'b10, 1'b1, 1'b0, 2'b0, 8'd4,  8'h07, 8'hB0}
  };

  function automatic int bw(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b10) ? 2 : 4;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0]  ref_b [256];
    int          rb0, wb0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int r = 0; r < 5; r++) begin
      rd_reg(3'(r), v);
      check(v == 0, "R1 reg reset", v, 0);
    end
    check(!mreq && !irq, "R1 req/irq reset", {mreq, irq}, 0);

    // R2 R3 R4 R5 R6: vector table
    for (int t = 0; t < 6; t++) begin
      logic [1:0] ss, ds;
      bit sf, df;
      int cnt, sa, da, mism;
      {ss, ds, sf, df} = VEC[t][31:26];
      cnt = int'(VEC[t][23:16]); sa = int'(VEC[t][15:8]); da = int'(VEC[t][7:0]);
      reload_mem();
      wr_reg(3'd4, 32'h2);
      wr_reg(3'd0, 32'(sa));
      wr_reg(3'd1, 32'(da));
      wr_reg(3'd2, 32'(cnt));
      rb0 = rd_beats; wb0 = wr_beats;
      wr_reg(3'd3, mk_mode(ss, ds, sf, df, 1'b0, 1'b1));
      wait_done();
      for (int b = 0; b < 256; b++) ref_b[b] = init_byte(b);
      for (int i = 0; i < cnt; i++) begin
        int s_a, d_a;
        s_a = sf ? sa + (i % bw(ss)) : sa + i;
        d_a = df ? da + (i % bw(ds)) : da + i;
        ref_b[d_a & 255] = init_byte(s_a & 255);
      end
      mism = 0;
      for (int b = 0; b < 256; b++)
        if (mem[b/4][8*(b%4) +: 8] != ref_b[b]) mism++;
      check(mism == 0, $sformatf("R2 R6 R4 vec%0d memory", t), mism, 0);
      check(rd_beats - rb0 == cnt / bw(ss), $sformatf("R3 vec%0d read beats", t), rd_beats - rb0, cnt / bw(ss));
      check(wr_beats - wb0 == cnt / bw(ds), $sformatf("R3 vec%0d write beats", t), wr_beats - wb0, cnt / bw(ds));
      rd_reg(3'd2, v);
      check(v == 0, $sformatf("R5 vec%0d residue", t), v, 0);
      rd_reg(3'd4, v);
      check(v[1:0] == 2'b10, $sformatf("R9 vec%0d done", t), v, 2);
      check(irq == 1'b1, $sformatf("R9 vec%0d irq", t), irq, 1);
    end

    // R9 clear done
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd4, v);
    check(v[1] == 0 && irq == 0, "R9 done cleared", {v[1], irq}, 0);

    // R8 misaligned incrementing source
    rb0 = rd_beats;
    wr_reg(3'd0, 32'h02); wr_reg(3'd1, 32'h80); wr_reg(3'd2, 32'd8);
    wr_reg(3'd3, mk_mode(2'b00, 2'b00, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    rd_reg(3'd4, v);
    check(v[2:0] == 3'b100, "R8 misalign error", v, 4);
    check(rd_beats == rb0, "R8 no bus cycles", rd_beats - rb0, 0);
    wr_reg(3'd4, 32'h2);
    rd_reg(3'd4, v);
    check(v[2] == 0, "R9 error cleared", v, 0);
    // R8 count not a multiple of unit
    wr_reg(3'd0, 32'h00); wr_reg(3'd2, 32'd6);
    wr_reg(3'd3, mk_mode(2'b00, 2'b00, 0, 0, 0, 1));
    rd_reg(3'd4, v);
    check(v[2:0] == 3'b100, "R8 count error", v, 4);
    wr_reg(3'd4, 32'h2);

    // R12 zero count
    rb0 = rd_beats;
    wr_reg(3'd2, 32'd0);
    wr_reg(3'd3, mk_mode(2'b00, 2'b00, 0, 0, 0, 0));
    rd_reg(3'd4, v);
    check(v[2:0] == 3'b010 && rd_beats == rb0, "R12 zero count done", v, 2);
    check(irq == 0, "R9 irq masked", irq, 0);
    wr_reg(3'd4, 32'h2);

    // R7 cycle steal, R11 busy write ignore
    reload_mem();
    wr_reg(3'd0, 32'h40); wr_reg(3'd1, 32'hC0); wr_reg(3'd2, 32'd12);
    rb0 = rd_beats; wb0 = wr_beats;
    wr_reg(3'd3, mk_mode(2'b00, 2'b00, 0, 0, 1, 0));
    repeat (10) @(negedge clk);
    rd_reg(3'd2, v);
    check(v == 12 && rd_beats == rb0, "R7 idle without request", v, 12);
    @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
    repeat (15) @(negedge clk);
    rd_reg(3'd2, v);
    check(v == 8, "R7 one unit count", v, 8);
    check(rd_beats - rb0 == 1 && wr_beats - wb0 == 1, "R7 one unit beats", rd_beats - rb0, 1);
    begin
      logic [31:0] a0, a1, c1;
      rd_reg(3'd0, a0);
      wr_reg(3'd0, 32'hFF);
      wr_reg(3'd2, 32'd100);
      rd_reg(3'd0, a1);
      rd_reg(3'd2, c1);
      check(a1 == a0 && a0 == 32'h44, "R11 src write ignored", a1, 32'h44);
      check(c1 == 8, "R11 count write ignored", c1, 8);
    end
    for (int p = 0; p < 2; p++) begin
      @(negedge clk); ext_req = 1'b1; @(negedge clk); ext_req = 1'b0;
      repeat (15) @(negedge clk);
    end
    rd_reg(3'd4, v);
    check(v[1:0] == 2'b10 && rd_beats - rb0 == 3, "R7 completes after three requests", v, 2);
    check(mem[50] == {init_byte(75), init_byte(74), init_byte(73), init_byte(72)}, "R7 last word", mem[50], 0);
    wr_reg(3'd4, 32'h2);

    // R10 abort
    wr_reg(3'd0, 32'h00); wr_reg(3'd1, 32'h80); wr_reg(3'd2, 32'd64);
    wr_reg(3'd3, mk_mode(2'b00, 2'b00, 0, 0, 0, 0));
    repeat (7) @(negedge clk);
    wr_reg(3'd3, 32'h0);
    repeat (4) @(negedge clk);
    rb0 = rd_beats; wb0 = wr_beats;
    repeat (20) @(negedge clk);
    check(rd_beats == rb0 && wr_beats == wb0 && !mreq, "R10 bus quiet after stop", rd_beats - rb0, 0);
    rd_reg(3'd4, v);
    check(v[1:0] == 2'b00, "R10 not busy, not done", v, 0);
    rd_reg(3'd2, v);
    check(v > 0 && v < 64 && v[1:0] == 0, "R10 residue partial", v, 60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule